// File: doc/BRIEF.md
# LFSR-Addressed FIFO Pointer Unit

This block keeps the write and read pointers of a circular buffer held in an external SRAM (32K words of 16 bits by default). Neither pointer counts in binary. Each one steps through the states of a maximal-length linear feedback shift register. With an XNOR feedback, such a register visits 2^W-1 distinct addresses and never enters the all-ones state. The SRAM strobes and the data path belong to neighbouring logic. This unit only presents the active address and advances it when an access completes.

A mode input chooses record or extract. In record mode the write pointer drives the address bus, and every accepted access moves the write pointer on. In extract mode the read pointer drives the bus, and every accepted access moves the read pointer on. LFSR addresses cannot be subtracted to find the fill level. A binary occupancy counter runs alongside the pointers instead, and it produces the empty, almost-full and full flags. Upstream logic turns almost-full into a stall request. Upstream logic treats full as the signal to stop recording and begin extraction. Only the module whose select input is high reacts to the shared trigger.

Top module: `lfsr_fifo_ptr`

## Requirements
- R1: While reset is asserted and after it is released, both pointers hold SEED, empty is 1, and almost_full and full are 0.
- R2: addr equals the read pointer when extract is 1 and the write pointer when extract is 0. addr is combinational from the pointer registers.
- R3: At a rising clock edge where sel=1, trig=1, extract=0 and full=0, the write pointer advances to its LFSR successor: next = {q[W-2:0], fb}. fb is the XNOR of the tap bits, which are bits 4 and 2 for W=5 and bits 14 and 13 for W=15. The occupancy count goes up by one.
- R4: At a rising clock edge where sel=1, trig=1, extract=1 and empty=0, the read pointer advances by the same LFSR step, and the count goes down by one.
- R5: A pointer returns to its start value after exactly 2^W-1 advances, visits every value other than all-ones once per period, and is never all-ones.
- R6: With sel=0, trig has no effect on the pointers or the flags.
- R7: A write while full and a read while empty are ignored. Neither pointer moves and the count is unchanged.
- R8: empty is 1 exactly when the count is 0. full is 1 exactly when the count is 2^W-1.
- R9: almost_full is 1 exactly when the count is at least 2^W-1-AF_MARGIN.
- R10: The flags are combinational from the registered count. They change after the same clock edge that moves a pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Module select; gates trig |
| extract | input | 1 | 1 = extract (read) mode, 0 = record (write) mode |
| trig | input | 1 | One access completes at this clock edge |
| addr | output | ADDR_W | SRAM address from the active pointer |
| empty | output | 1 | Count is zero |
| almost_full | output | 1 | Count at or above threshold |
| full | output | 1 | Count at its maximum |

## Verification
The bench builds the unit with ADDR_W=5, AF_MARGIN=4 and SEED=1. With these values the pointer period is 31 and the almost-full threshold is 27. A few dozen writes therefore reach the full boundary, wrap the write pointer around its whole sequence, and test the writes refused at full and the reads refused at empty. The default 15-bit width would need about 32K cycles per fill. At the small width the period, the lock-up state and the flag edges are all exercised many times. The bench runs directed fills and drains, then a long random mix of modes, selects and triggers, and compares the unit against a behavioural model on every cycle.

// File: rtl/lfsr_fifo_pkg.sv
package lfsr_fifo_pkg;

  // Tap set (bit positions, zero based) for a maximal-length XNOR LFSR
  function automatic logic [15:0] tap_mask(input int w);
    logic [15:0] m;
    case (w)
      3:  m = 16'h0006;
      4:  m = 16'h000C;
      5:  m = 16'h0014;
      6:  m = 16'h0030;
      7:  m = 16'h0060;
      8:  m = 16'h00B8;
      9:  m = 16'h0110;
      10: m = 16'h0240;
      11: m = 16'h0500;
      12: m = 16'h0829;
      13: m = 16'h100D;
      14: m = 16'h2015;
      15: m = 16'h6000;
      default: m = 16'hD008;
    endcase
    return m;
  endfunction

  // One LFSR step: shift toward MSB, XNOR of taps enters at bit 0
  function automatic logic [15:0] lfsr_next(input logic [15:0] q,
                                            input logic [15:0] mask,
                                            input int w);
    logic [15:0] wmask;
    logic        fb;
    wmask = 16'((32'd1 << w) - 1);
    fb    = ~(^(q & mask));
    return ((q << 1) | {15'd0, fb}) & wmask;
  endfunction

endpackage

// File: rtl/lfsr_ptr.sv
module lfsr_ptr
  import lfsr_fifo_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter logic [ADDR_W-1:0] SEED = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [ADDR_W-1:0] q
);
  localparam logic [15:0] MASK = tap_mask(ADDR_W);
  localparam logic [ADDR_W-1:0] LOCK = '1;

  logic [15:0]       q_wide;
  logic [ADDR_W-1:0] q_nxt;

  assign q_wide = 16'(q);
  assign q_nxt  = ADDR_W'(lfsr_next(q_wide, MASK, ADDR_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= SEED;
    else if (adv) q <= q_nxt;
  end

  // R5: the lock-up state is never entered
  a_r5_no_lockup: assert property (@(posedge clk) disable iff (!rst_n)
    q != LOCK);
  // R3 / R4: an advance always changes the pointer
  a_r3_adv_moves: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> q != $past(q));
  // R7: without advance the pointer holds
  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(q));

endmodule

// File: rtl/occ_counter.sv
module occ_counter #(
  parameter int ADDR_W    = 15,
  parameter int AF_MARGIN = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic empty,
  output logic almost_full,
  output logic full
);
  localparam int DEPTH  = (1 << ADDR_W) - 1;
  localparam int THRESH = DEPTH - AF_MARGIN;
  localparam logic [ADDR_W-1:0] CMAX = ADDR_W'(DEPTH);
  localparam logic [ADDR_W-1:0] CTHR = ADDR_W'(THRESH);

  logic [ADDR_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (inc && !dec) cnt <= cnt + 1'b1;
    else if (dec && !inc) cnt <= cnt - 1'b1;
  end

  assign empty       = (cnt == '0);
  assign full        = (cnt == CMAX);
  assign almost_full = (cnt >= CTHR);

  // R7: no increment at full, no decrement at empty
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !inc);
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !dec);
  // R8: flags never both set
  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));
  // R9: full implies almost full
  a_r9_af_covers_full: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> almost_full);

endmodule

// File: rtl/lfsr_fifo_ptr.sv
module lfsr_fifo_ptr #(
  parameter int ADDR_W    = 15,
  parameter int AF_MARGIN = 256,
  parameter logic [ADDR_W-1:0] SEED = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              extract,
  input  logic              trig,
  output logic [ADDR_W-1:0] addr,
  output logic              empty,
  output logic              almost_full,
  output logic              full
);
  logic              access;
  logic              wr_go;
  logic              rd_go;
  logic [ADDR_W-1:0] wp;
  logic [ADDR_W-1:0] rp;

  assign access = sel && trig;
  assign wr_go  = access && !extract && !full;
  assign rd_go  = access &&  extract && !empty;

  lfsr_ptr #(.ADDR_W(ADDR_W), .SEED(SEED)) u_wp (
    .clk(clk), .rst_n(rst_n), .adv(wr_go), .q(wp));

  lfsr_ptr #(.ADDR_W(ADDR_W), .SEED(SEED)) u_rp (
    .clk(clk), .rst_n(rst_n), .adv(rd_go), .q(rp));

  occ_counter #(.ADDR_W(ADDR_W), .AF_MARGIN(AF_MARGIN)) u_occ (
    .clk(clk), .rst_n(rst_n), .inc(wr_go), .dec(rd_go),
    .empty(empty), .almost_full(almost_full), .full(full));

  assign addr = extract ? rp : wp;

  // R6: unselected module keeps both pointers
  a_r6_unselected_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(wp) && $stable(rp));
  // R3: a write leaves the read pointer alone
  a_r3_write_only_wp: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && trig && !extract) |=> $stable(rp));
  // R4: a read leaves the write pointer alone
  a_r4_read_only_rp: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && trig && extract) |=> $stable(wp));
  // R8: equal pointers after a write mean the buffer filled
  a_r8_wrap_means_full: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !empty) |=> (wp != rp) || full);

endmodule

// File: tb/sim_lfsr_fifo_ptr.sv
`timescale 1ns/1ps
module sim_lfsr_fifo_ptr;
  localparam int W = 5;
  localparam int MARGIN = 4;
  localparam int DEPTH = (1 << W) - 1;
  localparam int SEEDV = 1;

  logic clk = 0, rst_n = 0, sel = 0, extract = 0, trig = 0;
  logic [W-1:0] addr;
  logic empty, almost_full, full;

  int n_chk = 0, n_fail = 0;
  int m_wp, m_rp, m_cnt;
  bit done = 0;

  always #5 clk = ~clk;

  lfsr_fifo_ptr #(.ADDR_W(W), .AF_MARGIN(MARGIN), .SEED(W'(SEEDV))) u0 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .extract(extract), .trig(trig),
    .addr(addr), .empty(empty), .almost_full(almost_full), .full(full));

  // Taps at bits 4 and 2, feedback is the inverted parity of those bits
  function automatic int step(input int q);
    int b4, b2;
    b4 = (q >> 4) & 1;
    b2 = (q >> 2) & 1;
    return ((q * 2) + ((b4 == b2) ? 1 : 0)) % 32;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare_all();
    int exp_addr;
    exp_addr = extract ? m_rp : m_wp;
    chk(addr == W'(exp_addr), extract ? "R2/R4 addr" : "R2/R3 addr", addr, exp_addr);
    chk(empty == (m_cnt == 0), "R8 empty", empty, m_cnt == 0);
    chk(full == (m_cnt == DEPTH), "R8 full", full, m_cnt == DEPTH);
    chk(almost_full == (m_cnt >= DEPTH - MARGIN), "R9 almost_full",
        almost_full, m_cnt >= DEPTH - MARGIN);
    chk(addr != W'(DEPTH), "R5 lockup", addr, 0);
  endtask

  // One clock: inputs applied now, model updated at the edge, compared at negedge
  task automatic cyc(input bit s, input bit e, input bit t);
    sel = s; extract = e; trig = t;
    @(posedge clk);
    if (s && t && !e && m_cnt < DEPTH) begin m_wp = step(m_wp); m_cnt++; end
    else if (s && t && e && m_cnt > 0) begin m_rp = step(m_rp); m_cnt--; end
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seen;
    int p;
    m_wp = SEEDV; m_rp = SEEDV; m_cnt = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(addr == W'(SEEDV) && empty && !almost_full && !full, "R1 reset", addr, SEEDV);
    rst_n = 1;
    @(negedge clk);
    compare_all();
    extract = 1; #1;
    chk(addr == W'(SEEDV), "R1 rp seed", addr, SEEDV);
    @(negedge clk);

    // R3: a few writes
    for (int i = 0; i < 5; i++) cyc(1, 0, 1);
    // R6: unselected triggers ignored
    for (int i = 0; i < 6; i++) cyc(0, i % 2, 1);
    chk(m_cnt == 5 && !empty, "R6 count kept", empty, 0);
    // R4 and R7: drain past empty
    for (int i = 0; i < 7; i++) cyc(1, 1, 1);
    chk(empty == 1, "R7 read at empty", empty, 1);

    // R5: full period of the write pointer, tracking distinct values
    seen = 0;
    p = m_wp;
    for (int i = 0; i < DEPTH; i++) begin
      seen = seen | (1 << addr);
      cyc(1, 0, 1);
    end
    chk(seen == 32'h7FFF_FFFF, "R5 all states visited", seen, 32'h7FFF_FFFF);
    chk(addr == W'(p), "R5 period return", addr, p);
    chk(full == 1, "R8 full at depth", full, 1);
    // R7: writes while full
    for (int i = 0; i < 4; i++) cyc(1, 0, 1);
    chk(addr == W'(p), "R7 write at full ignored", addr, p);
    // R9/R10: drain across the threshold
    for (int i = 0; i < DEPTH + 2; i++) cyc(1, 1, 1);

    // Random mix
    for (int i = 0; i < 4000; i++)
      cyc(($urandom % 8) != 0, ($urandom % 2) == 1, ($urandom % 4) != 0);
    for (int i = 0; i < 3000; i++)
      cyc(1, ($urandom % 5) == 0, 1);
    for (int i = 0; i < 3000; i++)
      cyc(1, ($urandom % 5) != 0, 1);

    // R1: reset in the middle of activity
    rst_n = 0; #1;
    m_wp = SEEDV; m_rp = SEEDV; m_cnt = 0;
    chk(empty && !full && !almost_full && addr == W'(SEEDV), "R1 mid reset", addr, SEEDV);
    @(negedge clk);
    rst_n = 1;
    cyc(1, 0, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule